// File: doc/BRIEF.md
# Shift-Register Clock Divider with Post-Divider

This block divides its input clock with two programmable dividers that count through a pseudo-random shift-register sequence rather than a binary count. There is a 6-bit reference divider and an 8-bit feedback divider. Each one holds a state register that steps through a fixed sequence. When the register reaches the all-ones terminal state, it reloads from a software-written reload value and its output toggles. A division ratio N is chosen by writing the sequence element that lies N-1 steps before the terminal state. The output half-period is then N input clocks.

A post-divider runs beside the two dividers. It is a cascade of two 1-to-8 counters whose output half-period is the product of the two ratios. Each ratio is written as eight minus the ratio in a packed 6-bit word. A ratio of 8 is therefore written as the field value 0. Software that selects a ratio of 8 first writes a temporary value, waits briefly, and then writes the final value. The block absorbs that sequence by applying new post-divider ratios only at half-period boundaries.

All three outputs come from one clock domain. A single write port selects which setting to update.

Top module: `lfsr_clk_divider`

## Requirements
- R1: The reference output has a half-period of N clocks for these reload values: 0x3F→1, 0x00→2, 0x20→3, 0x25→10, 0x08→20, 0x06→30, 0x21→40, 0x27→50, 0x1F→60 and 0x01→64.
- R2: The feedback output has a half-period of N clocks for these reload values: 0x00→2, 0x80→3, 0x2F→10, 0xA7→20, 0xFC→50, 0x3C→100 and 0x69→160.
- R3: State stepping:
  - Each state shifts left by one bit.
  - The new LSB is the XNOR of the tapped bits: bits 5 and 4 for the 6-bit divider, and bits 7, 3, 2 and 1 for the 8-bit divider.
  - The all-zero state steps to the all-ones terminal state.
  - At the terminal state the register loads the reload value and the output toggles. The output changes at no other time.
- R4: A write to a reload value takes effect at the next terminal event. The half-period in progress is completed at its old length and is never shortened.
- R5: The post-divider word is packed as follows, and the post output half-period is pd1×pd2 clocks:
  - bits [2:0] hold 8−pd1;
  - bits [5:3] hold 8−pd2;
  - a field value of 0 means a ratio of 8.
- R6: A new post-divider word is applied only at a post output toggle. For the ratio-8 sequence (write 0x09, then write 0x00), every full half-period is 49 clocks until the final word is applied, and 64 clocks after it.
- R7: Reset and power-up:
  - While reset is asserted, all three outputs are low.
  - Reset sets the reference reload to 0x3F (÷1), the feedback reload to 0x00 (÷2) and the post word to 0x3F (1×1).
  - After reset is released, the half-periods are 1, 2 and 1 clocks respectively.
- R8: Write decoding:
  - With `wr_en` high, `wr_sel` 0 writes the reference reload, 1 writes the feedback reload and 2 writes the post word.
  - `wr_sel` 3 has no effect.
  - Nothing is written while `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Setting write strobe |
| wr_sel | input | 2 | Target: 0 reference reload, 1 feedback reload, 2 post word, 3 none |
| wr_data | input | 8 | Write value (low 6 bits used for the reference reload and the post word) |
| ref_div_o | output | 1 | Reference divider output |
| fb_div_o | output | 1 | Feedback divider output |
| post_div_o | output | 1 | Post-divider output |

## Verification
A table of reload values drives both dividers:
- The minimum, second and largest divisors confirm the terminal handling and the zero-to-terminal step.
- The mid-range entries spread across the sequence, so a wrong tap shows up as a wrong half-period.

Post-divider words are tested as follows:
- Equal and unequal ratio pairs show that the two fields are not swapped.
- The field value 0 shows that it decodes as 8.

A write made in the middle of a long half-period separates a correct next-terminal reload from an immediate one. The ratio-8 write sequence shows that only whole half-periods of the written settings appear.

// File: rtl/lfsr_div_pkg.sv
// Shared definitions for the shift-register clock divider.
// Assumes a single clock domain; the write select codes are fixed here.
package lfsr_div_pkg;

    typedef enum logic [1:0] {
        SEL_REF  = 2'd0,
        SEL_FB   = 2'd1,
        SEL_POST = 2'd2,
        SEL_NONE = 2'd3
    } wr_target_e;

endpackage

// File: rtl/lfsr_divider.sv
// Divider that counts with an XNOR shift register.
// The state shifts left with the XNOR of the TAPS bits entering at bit 0.
// The all-zero state steps to the all-ones terminal state. At the terminal
// state the register loads reload_i and div_o toggles, so a reload value
// placed N-1 steps before the terminal gives a half-period of N clocks.
// Assumes reload_i is held by the caller; it is sampled only at the terminal.
module lfsr_divider #(
    parameter int                 WIDTH = 6,
    parameter logic [WIDTH-1:0]   TAPS  = 6'h30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] reload_i,
    output logic             div_o
);

    localparam logic [WIDTH-1:0] TERM = {WIDTH{1'b1}};

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] step_d;
    logic             at_term;

    // Next state on the sequence, with the zero state routed to the terminal.
    always_comb begin
        at_term = (state_q == TERM);
        if (state_q == '0)
            step_d = TERM;
        else
            step_d = {state_q[WIDTH-2:0], ~^(state_q & TAPS)};
    end

    // State register: step, or reload and toggle at the terminal state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TERM;
            div_o   <= 1'b0;
        end else if (at_term) begin
            state_q <= reload_i;
            div_o   <= ~div_o;
        end else begin
            state_q <= step_d;
        end
    end

    AST_RELOAD_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TERM) |=> (state_q == $past(reload_i))); // R4
    AST_HOLD_OFF_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TERM) |=> $stable(div_o)); // R3
    AST_ZERO_TO_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0) |=> (state_q == TERM)); // R3

endmodule

// File: rtl/post_divider.sv
// Cascade of STAGES programmable counters. Each stage has a ratio of 1 to
// 2**FIELD_W, encoded as 2**FIELD_W minus the ratio, so field 0 means the
// largest ratio. The output toggles when every stage wraps at once, which
// gives a half-period equal to the product of the ratios. New fields are
// taken only at that toggle, so a half-period always runs whole.
module post_divider #(
    parameter int FIELD_W = 3,
    parameter int STAGES  = 2,
    localparam int RATIO_W = FIELD_W + 1,
    localparam int WORD_W  = FIELD_W * STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fields_i,
    output logic              div_o
);

    localparam logic [RATIO_W-1:0] FULL = RATIO_W'(2 ** FIELD_W);

    logic [STAGES-1:0][RATIO_W-1:0] act_q;
    logic [STAGES-1:0][RATIO_W-1:0] cnt_q;
    logic [STAGES-1:0][RATIO_W-1:0] ratio_d;
    logic [STAGES:0]                tick;
    logic                           boundary;

    assign tick[0] = 1'b1;

    // One decode and wrap detector per stage; each stage advances on the
    // wrap of the stage before it.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        assign ratio_d[s]  = FULL - {1'b0, fields_i[s*FIELD_W +: FIELD_W]};
        assign tick[s+1]   = tick[s] && (cnt_q[s] == act_q[s] - 1'b1);

        AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[s] < act_q[s]); // R5
    end

    assign boundary = tick[STAGES];

    // Counter, active ratio and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                cnt_q[s] <= '0;
                act_q[s] <= RATIO_W'(1);
            end
            div_o <= 1'b0;
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                if (tick[s+1])
                    cnt_q[s] <= '0;
                else if (tick[s])
                    cnt_q[s] <= cnt_q[s] + 1'b1;
            end
            if (boundary) begin
                act_q <= ratio_d;
                div_o <= ~div_o;
            end
        end
    end

    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(act_q)); // R6
    AST_TOGGLE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(div_o)); // R5

endmodule

// File: rtl/lfsr_clk_divider.sv
// Top level: holds the write-selected settings and feeds the reference
// divider, the feedback divider and the post-divider. Everything runs on
// clk, with a synchronous active-low reset.
module lfsr_clk_divider
    import lfsr_div_pkg::*;
#(
    parameter int                REF_W      = 6,
    parameter logic [REF_W-1:0]  REF_TAPS   = 6'h30,
    parameter int                FB_W       = 8,
    parameter logic [FB_W-1:0]   FB_TAPS    = 8'h8E,
    parameter int                PD_FIELD_W = 3,
    parameter int                PD_STAGES  = 2,
    parameter int                DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ref_div_o,
    output logic              fb_div_o,
    output logic              post_div_o
);

    localparam int               POST_W   = PD_FIELD_W * PD_STAGES;
    localparam logic [REF_W-1:0] REF_RST  = {REF_W{1'b1}};
    localparam logic [FB_W-1:0]  FB_RST   = '0;
    localparam logic [POST_W-1:0] POST_RST = {POST_W{1'b1}};

    logic [REF_W-1:0]  ref_rl_q;
    logic [FB_W-1:0]   fb_rl_q;
    logic [POST_W-1:0] post_q;

    // Setting registers, written by the selected target only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_rl_q <= REF_RST;
            fb_rl_q  <= FB_RST;
            post_q   <= POST_RST;
        end else if (wr_en) begin
            case (wr_target_e'(wr_sel))
                SEL_REF:  ref_rl_q <= wr_data[REF_W-1:0];
                SEL_FB:   fb_rl_q  <= wr_data[FB_W-1:0];
                SEL_POST: post_q   <= wr_data[POST_W-1:0];
                default:  ;
            endcase
        end
    end

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == SEL_NONE) |=>
        ($stable(ref_rl_q) && $stable(fb_rl_q) && $stable(post_q))); // R8

    lfsr_divider #(.WIDTH(REF_W), .TAPS(REF_TAPS)) u_ref_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (ref_rl_q),
        .div_o    (ref_div_o)
    );

    lfsr_divider #(.WIDTH(FB_W), .TAPS(FB_TAPS)) u_fb_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (fb_rl_q),
        .div_o    (fb_div_o)
    );

    post_divider #(.FIELD_W(PD_FIELD_W), .STAGES(PD_STAGES)) u_post_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .fields_i (post_q),
        .div_o    (post_div_o)
    );

endmodule

// File: tb/lfsr_clk_divider_tb.sv
module lfsr_clk_divider_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ref_div_o, fb_div_o, post_div_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lfsr_clk_divider u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ref_div_o  (ref_div_o),
        .fb_div_o   (fb_div_o),
        .post_div_o (post_div_o)
    );

    // Vector: {target, write value, expected half-period}
    localparam int NV = 22;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 8'h3F, 10'd1},  {2'd0, 8'h00, 10'd2},  {2'd0, 8'h20, 10'd3},
        {2'd0, 8'h25, 10'd10}, {2'd0, 8'h08, 10'd20}, {2'd0, 8'h06, 10'd30},
        {2'd0, 8'h21, 10'd40}, {2'd0, 8'h27, 10'd50}, {2'd0, 8'h1F, 10'd60},
        {2'd0, 8'h01, 10'd64},
        {2'd1, 8'h00, 10'd2},  {2'd1, 8'h80, 10'd3},  {2'd1, 8'h2F, 10'd10},
        {2'd1, 8'hA7, 10'd20}, {2'd1, 8'hFC, 10'd50}, {2'd1, 8'h3C, 10'd100},
        {2'd1, 8'h69, 10'd160},
        {2'd2, 8'h3F, 10'd1},  {2'd2, 8'h3E, 10'd2},  {2'd2, 8'h35, 10'd6},
        {2'd2, 8'h1B, 10'd25}, {2'd2, 8'h00, 10'd64}
    };

    function automatic logic out_of(input int k);
        case (k)
            0:       return ref_div_o;
            1:       return fb_div_o;
            default: return post_div_o;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count negedges until the selected output changes.
    task automatic wait_toggle(input int k, output int cycles);
        logic v;
        v = out_of(k);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (out_of(k) == v && cycles < 400);
    endtask

    // Skip the half-period in progress, then measure the next one.
    task automatic settle_measure(input int k, output int h);
        int c;
        wait_toggle(k, c);
        wait_toggle(k, h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int h, c;
        // R7: outputs low while reset is held
        repeat (4) @(negedge clk);
        check("R7 ref low in reset", int'(ref_div_o), 0);
        check("R7 fb low in reset", int'(fb_div_o), 0);
        check("R7 post low in reset", int'(post_div_o), 0);
        rst_n = 1'b1;
        // R7: default ratios after reset
        settle_measure(0, h); check("R7 ref default", h, 1);
        settle_measure(1, h); check("R7 fb default", h, 2);
        settle_measure(2, h); check("R7 post default", h, 1);

        // R1 R2 R3 R5: table walk
        for (int i = 0; i < NV; i++) begin
            int k, exp;
            k   = int'(VEC[i][19:18]);
            exp = int'(VEC[i][9:0]);
            wr(VEC[i][19:18], VEC[i][17:10]);
            settle_measure(k, h);
            check(k == 0 ? "R1 ref half" : (k == 1 ? "R2 fb half" : "R5 post half"), h, exp);
            wait_toggle(k, h);
            check(k == 0 ? "R3 ref repeat" : (k == 1 ? "R3 fb repeat" : "R5 post repeat"), h, exp);
        end

        // R4: reload written mid-half does not shorten it (ref at 64 now)
        wait_toggle(0, c);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h00);
        wait_toggle(0, h);
        check("R4 current half kept", h + 7, 64);
        wait_toggle(0, h);
        check("R4 new ratio next", h, 2);

        // R8: select 3 and wr_en low change nothing
        wr(2'd1, 8'h80);
        settle_measure(1, h);
        check("R8 fb setup", h, 3);
        wr(2'd3, 8'h00);
        settle_measure(1, h);
        check("R8 sel3 fb unchanged", h, 3);
        settle_measure(0, h);
        check("R8 sel3 ref unchanged", h, 2);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h20;
        settle_measure(0, h);
        check("R8 no write without enable", h, 2);

        // R6: ratio-8 workaround sequence
        wr(2'd2, 8'h3E);
        settle_measure(2, h);
        check("R6 post start", h, 2);
        wr(2'd2, 8'h09);
        settle_measure(2, h);
        check("R6 temporary 7x7", h, 49);
        wr(2'd2, 8'h00);
        settle_measure(2, h);
        check("R6 final 8x8", h, 64);
        wait_toggle(2, h);
        check("R6 final 8x8 repeat", h, 64);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule